// File: doc/BRIEF.md
# Process-Tagged Fully Associative Translation Cache

This block caches recent virtual-to-physical page translations for a 32-bit virtual address space mapped onto a 30-bit physical space with 2 KB pages. The low 11 address bits are the page offset and pass straight through. The upper 21 virtual bits are the page number, and they translate to a 19-bit physical page number. Every entry also carries the process identifier that owns it, so translations from several processes can live side by side. A lookup compares both the page number and the identifier of the running process against every entry at once. In the same cycle it reports one of three results: a hit with the physical address, a permission fault, or a miss.

On a miss, an external page-table walker fetches the translation and writes it through the refill port. The refill lands in the lowest-numbered free slot. When no slot is free, it replaces the least recently used entry. If the same page and process are already present, the refill overwrites that entry in place. A single flush input, pulsed on a task switch, drops every entry.

Top module: `pid_tlb`

## Requirements
- R1: When `lk_valid` is high and a valid entry matches and the access is allowed, `lk_hit` is 1 in the same cycle, with no register on the path, and `lk_paddr` equals {entry physical page, `lk_vaddr[10:0]`}.
- R2: An entry matches only when its 21-bit page number equals `lk_vaddr[31:11]` and its process identifier equals `lk_pid`. A difference in either field gives `lk_miss`=1.
- R3: Permission bits are bit0 read, bit1 write, bit2 execute and bit3 user-accessible. Access codes on `lk_acc` are 0 load (needs read), 1 store (needs write), 2 fetch (needs execute) and 3, which is checked as a load. The access is also refused when `lk_user`=1 and bit3 is clear. A refused match gives `lk_fault`=1 with `lk_hit`=0 and `lk_miss`=0.
- R4: When `lk_valid` is high and no valid entry matches, `lk_miss`=1. When `lk_valid` is low, `lk_hit`, `lk_miss`, `lk_fault` and `lk_paddr` are all 0.
- R5: A cycle with `flush` high invalidates all entries from the next cycle on. A refill in the same cycle is dropped. A lookup in the flush cycle still sees the old contents.
- R6: A refill with no matching entry writes the lowest-indexed invalid entry.
- R7: When all entries are valid, a new refill replaces the least recently used entry. Use is recorded for refills and for hits. Faults and misses are not recorded, and a hit in a cycle that also carries a refill is not recorded.
- R8: A refill whose page number and process identifier match a valid entry overwrites that entry, so no duplicate ever exists.
- R9: After reset every entry is invalid.
- R10: A refill takes effect in the cycle after it is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_valid | input | 1 | Lookup request |
| lk_vaddr | input | 32 | Virtual address to translate |
| lk_pid | input | 8 | Process identifier of the request |
| lk_acc | input | 2 | Access kind: 0 load, 1 store, 2 fetch |
| lk_user | input | 1 | Request made in user mode |
| lk_hit | output | 1 | Allowed translation found |
| lk_miss | output | 1 | No matching entry |
| lk_fault | output | 1 | Matching entry refuses the access |
| lk_paddr | output | 30 | Translated physical address (0 unless hit) |
| rf_valid | input | 1 | Refill strobe from the walker |
| rf_vpn | input | 21 | Refill virtual page number |
| rf_pid | input | 8 | Refill process identifier |
| rf_ppn | input | 19 | Refill physical page number |
| rf_perm | input | 4 | Refill permission bits |
| flush | input | 1 | Invalidate all entries |

## Verification
Most internal corruption stays hidden until a later lookup reaches it. A stale valid bit after a flush shows up as a hit on the very next lookup of that page. A wrong usage order shows only when the cache is full and a refill evicts the wrong page, and a later lookup then misses or hits where the model disagrees, often many cycles on. The bench keeps a small page and process pool so that full-cache evictions and re-lookups happen often. This keeps the delay between a fault in the hardware and a visible port mismatch short.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
    localparam int VA_W     = 32;
    localparam int PA_W     = 30;
    localparam int PG_OFF_W = 11;
    localparam int VPN_W    = VA_W - PG_OFF_W;
    localparam int PPN_W    = PA_W - PG_OFF_W;
    localparam int PID_W    = 8;

    typedef enum logic [1:0] {
        ACC_LOAD  = 2'd0,
        ACC_STORE = 2'd1,
        ACC_FETCH = 2'd2,
        ACC_RSVD  = 2'd3
    } acc_e;

    typedef struct packed {
        logic usr;
        logic x;
        logic w;
        logic r;
    } perm_t;

    typedef struct packed {
        logic             vld;
        logic [PID_W-1:0] pid;
        logic [VPN_W-1:0] vpn;
        logic [PPN_W-1:0] ppn;
        perm_t            perm;
    } tlb_ent_t;

    function automatic logic perm_ok(perm_t p, acc_e a, logic user);
        logic ok;
        case (a)
            ACC_STORE: ok = p.w;
            ACC_FETCH: ok = p.x;
            default:   ok = p.r;
        endcase
        if (user && !p.usr) ok = 1'b0;
        return ok;
    endfunction
endpackage

// File: rtl/tlb_match.sv
module tlb_match
    import tlb_pkg::*;
#(
    parameter int N = 8
) (
    input  tlb_ent_t         ent [N],
    input  logic [VPN_W-1:0] vpn,
    input  logic [PID_W-1:0] pid,
    output logic [N-1:0]     hit_vec
);
    for (genvar i = 0; i < N; i++) begin : g_cmp
        assign hit_vec[i] = ent[i].vld && (ent[i].vpn == vpn) && (ent[i].pid == pid);
    end
endmodule

// File: rtl/tlb_lru.sv
module tlb_lru #(
    parameter int N  = 8,
    localparam int IW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          touch_en,
    input  logic [IW-1:0] touch_idx,
    output logic [IW-1:0] victim_idx
);
    logic [IW-1:0] age [N];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < N; i++) age[i] <= IW'(i);
        end else if (touch_en) begin
            for (int i = 0; i < N; i++) begin
                if (IW'(i) == touch_idx)
                    age[i] <= '0;
                else if (age[i] < age[touch_idx])
                    age[i] <= age[i] + 1'b1;
            end
        end
    end

    always_comb begin
        victim_idx = '0;
        for (int i = 0; i < N; i++)
            if (age[i] == IW'(N - 1)) victim_idx = IW'(i);
    end
endmodule

// File: rtl/pid_tlb.sv
module pid_tlb
    import tlb_pkg::*;
#(
    parameter int N = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             lk_valid,
    input  logic [VA_W-1:0]  lk_vaddr,
    input  logic [PID_W-1:0] lk_pid,
    input  logic [1:0]       lk_acc,
    input  logic             lk_user,
    output logic             lk_hit,
    output logic             lk_miss,
    output logic             lk_fault,
    output logic [PA_W-1:0]  lk_paddr,
    input  logic             rf_valid,
    input  logic [VPN_W-1:0] rf_vpn,
    input  logic [PID_W-1:0] rf_pid,
    input  logic [PPN_W-1:0] rf_ppn,
    input  logic [3:0]       rf_perm,
    input  logic             flush
);
    localparam int IW = $clog2(N);

    tlb_ent_t      ent [N];
    logic [N-1:0]  lk_vec, rf_vec, vld_vec;
    logic [IW-1:0] lk_idx, rf_idx, free_idx, victim_idx, wr_idx;
    logic          any_free, lk_any, rf_any, lk_ok;
    logic          touch_en;
    logic [IW-1:0] touch_idx;
    tlb_ent_t      lk_ent;

    for (genvar i = 0; i < N; i++) begin : g_vld
        assign vld_vec[i] = ent[i].vld;
    end

    tlb_match #(.N(N)) u_lk_match (
        .ent(ent), .vpn(lk_vaddr[VA_W-1:PG_OFF_W]), .pid(lk_pid), .hit_vec(lk_vec)
    );

    tlb_match #(.N(N)) u_rf_match (
        .ent(ent), .vpn(rf_vpn), .pid(rf_pid), .hit_vec(rf_vec)
    );

    always_comb begin
        lk_idx = '0;
        rf_idx = '0;
        for (int i = 0; i < N; i++) begin
            if (lk_vec[i]) lk_idx = IW'(i);
            if (rf_vec[i]) rf_idx = IW'(i);
        end
        free_idx = '0;
        any_free = 1'b0;
        for (int i = N - 1; i >= 0; i--) begin
            if (!vld_vec[i]) begin
                free_idx = IW'(i);
                any_free = 1'b1;
            end
        end
    end

    assign lk_any = |lk_vec;
    assign rf_any = |rf_vec;
    assign lk_ent = ent[lk_idx];
    assign lk_ok  = perm_ok(lk_ent.perm, acc_e'(lk_acc), lk_user);

    assign lk_hit   = lk_valid && lk_any && lk_ok;
    assign lk_fault = lk_valid && lk_any && !lk_ok;
    assign lk_miss  = lk_valid && !lk_any;
    assign lk_paddr = lk_hit ? {lk_ent.ppn, lk_vaddr[PG_OFF_W-1:0]} : '0;

    assign wr_idx = rf_any ? rf_idx : (any_free ? free_idx : victim_idx);

    assign touch_en  = !flush && (rf_valid || lk_hit);
    assign touch_idx = rf_valid ? wr_idx : lk_idx;

    tlb_lru #(.N(N)) u_lru (
        .clk(clk), .rst(rst), .touch_en(touch_en),
        .touch_idx(touch_idx), .victim_idx(victim_idx)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < N; i++) ent[i] <= '0;
        end else if (flush) begin
            for (int i = 0; i < N; i++) ent[i].vld <= 1'b0;
        end else if (rf_valid) begin
            ent[wr_idx] <= '{vld: 1'b1, pid: rf_pid, vpn: rf_vpn,
                             ppn: rf_ppn, perm: perm_t'(rf_perm)};
        end
    end
endmodule

// File: rtl/pid_tlb_chk.sv
module pid_tlb_chk
    import tlb_pkg::*;
#(
    parameter int N = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             lk_valid,
    input logic [VA_W-1:0]  lk_vaddr,
    input logic [PID_W-1:0] lk_pid,
    input logic             lk_hit,
    input logic             lk_miss,
    input logic             lk_fault,
    input logic [PA_W-1:0]  lk_paddr,
    input logic             rf_valid,
    input logic [VPN_W-1:0] rf_vpn,
    input logic [PID_W-1:0] rf_pid,
    input logic             flush,
    input logic [N-1:0]     lk_vec,
    input logic [N-1:0]     vld_vec
);
    AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (rst)
        lk_valid |-> $countones({lk_hit, lk_miss, lk_fault}) == 1); // R3
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !lk_valid |-> !lk_hit && !lk_miss && !lk_fault && lk_paddr == '0); // R4
    AST_OFFSET_PASS: assert property (@(posedge clk) disable iff (rst)
        lk_hit |-> lk_paddr[PG_OFF_W-1:0] == lk_vaddr[PG_OFF_W-1:0]); // R1
    AST_NO_DUPLICATE: assert property (@(posedge clk) disable iff (rst)
        $onehot0(lk_vec)); // R8
    AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (rst)
        flush |=> vld_vec == '0); // R5
    AST_REFILL_VISIBLE: assert property (@(posedge clk) disable iff (rst)
        ($past(rf_valid && !flush && !rst) && lk_valid &&
         lk_vaddr[VA_W-1:PG_OFF_W] == $past(rf_vpn) && lk_pid == $past(rf_pid))
        |-> !lk_miss); // R10
    AST_RESET_EMPTY: assert property (@(posedge clk)
        $past(rst) |-> vld_vec == '0); // R9
endmodule

bind pid_tlb pid_tlb_chk #(.N(N)) u_chk (
    .clk(clk), .rst(rst), .lk_valid(lk_valid), .lk_vaddr(lk_vaddr), .lk_pid(lk_pid),
    .lk_hit(lk_hit), .lk_miss(lk_miss), .lk_fault(lk_fault), .lk_paddr(lk_paddr),
    .rf_valid(rf_valid), .rf_vpn(rf_vpn), .rf_pid(rf_pid), .flush(flush),
    .lk_vec(lk_vec), .vld_vec(vld_vec)
);

// File: tb/pid_tlb_test.sv
module pid_tlb_test;
    localparam int CLK_PERIOD = 10;
    localparam int N = 8;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        lk_valid = 0, lk_user = 0, rf_valid = 0, flush = 0;
    logic [31:0] lk_vaddr = '0;
    logic [7:0]  lk_pid = '0, rf_pid = '0;
    logic [1:0]  lk_acc = '0;
    logic [20:0] rf_vpn = '0;
    logic [18:0] rf_ppn = '0;
    logic [3:0]  rf_perm = '0;
    logic        lk_hit, lk_miss, lk_fault;
    logic [29:0] lk_paddr;

    int errors = 0;
    int checks = 0;

    // behavioural model
    bit          m_v   [N];
    logic [20:0] m_vpn [N];
    logic [7:0]  m_pid [N];
    logic [18:0] m_ppn [N];
    logic [3:0]  m_perm[N];
    int          order[$];

    always #(CLK_PERIOD / 2) clk = ~clk;

    pid_tlb #(.N(N)) uut (
        .clk(clk), .rst(rst), .lk_valid(lk_valid), .lk_vaddr(lk_vaddr), .lk_pid(lk_pid),
        .lk_acc(lk_acc), .lk_user(lk_user), .lk_hit(lk_hit), .lk_miss(lk_miss),
        .lk_fault(lk_fault), .lk_paddr(lk_paddr), .rf_valid(rf_valid), .rf_vpn(rf_vpn),
        .rf_pid(rf_pid), .rf_ppn(rf_ppn), .rf_perm(rf_perm), .flush(flush)
    );

    task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    function automatic int find(logic [20:0] vpn, logic [7:0] pid);
        for (int i = 0; i < N; i++)
            if (m_v[i] && m_vpn[i] == vpn && m_pid[i] == pid) return i;
        return -1;
    endfunction

    function automatic bit allowed(logic [3:0] p, logic [1:0] acc, logic usr);
        bit need;
        if (acc == 2'd1) need = p[1];
        else if (acc == 2'd2) need = p[2];
        else need = p[0];
        return need && !(usr && !p[3]);
    endfunction

    function automatic void touch(int idx);
        for (int k = 0; k < order.size(); k++)
            if (order[k] == idx) begin order.delete(k); break; end
        order.push_front(idx);
    endfunction

    task automatic step(bit lv, logic [31:0] va, logic [7:0] pid, logic [1:0] acc, bit usr,
                        bit rv, logic [20:0] rvpn, logic [7:0] rpid, logic [18:0] rppn,
                        logic [3:0] rperm, bit fl, string tag);
        int  idx;
        bit  e_hit, e_miss, e_fault;
        logic [29:0] e_pa;
        string t;
        @(negedge clk);
        lk_valid = lv; lk_vaddr = va; lk_pid = pid; lk_acc = acc; lk_user = usr;
        rf_valid = rv; rf_vpn = rvpn; rf_pid = rpid; rf_ppn = rppn; rf_perm = rperm;
        flush = fl;
        #1;
        idx = find(va[31:11], pid);
        e_hit = 0; e_miss = 0; e_fault = 0; e_pa = '0;
        if (lv) begin
            if (idx < 0) e_miss = 1;
            else if (allowed(m_perm[idx], acc, usr)) begin
                e_hit = 1; e_pa = {m_ppn[idx], va[10:0]};
            end else e_fault = 1;
        end
        if (tag != "") t = tag;
        else if (e_fault) t = "R3";
        else if (e_hit) t = "R1";
        else if (lv) t = "R2";
        else t = "R4";
        chk(t, "hit",   32'(lk_hit),   32'(e_hit));
        chk(t, "miss",  32'(lk_miss),  32'(e_miss));
        chk(t, "fault", 32'(lk_fault), 32'(e_fault));
        chk(t, "paddr", 32'(lk_paddr), 32'(e_pa));
        @(posedge clk);
        if (fl) begin
            for (int i = 0; i < N; i++) m_v[i] = 0;
        end else if (rv) begin
            int w;
            w = find(rvpn, rpid);                 // R8 overwrite in place
            if (w < 0) begin
                for (int i = N - 1; i >= 0; i--) if (!m_v[i]) w = i;   // R6
            end
            if (w < 0) w = order[$];              // R7 least recently used
            m_v[w] = 1; m_vpn[w] = rvpn; m_pid[w] = rpid; m_ppn[w] = rppn; m_perm[w] = rperm;
            touch(w);
        end else if (e_hit) begin
            touch(idx);
        end
    endtask

    function automatic logic [31:0] va_of(logic [20:0] vpn);
        return {vpn, 11'(($urandom % 2048))};
    endfunction

    initial begin
        #(CLK_PERIOD * 150000);
        errors++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        for (int i = 0; i < N; i++) begin m_v[i] = 0; order.push_back(i); end
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 0;

        // R9: empty after reset
        step(1, va_of(21'h100), 8'd1, 2'd0, 0, 0, 0, 0, 0, 0, 0, "R9");

        // R10: refill then hit next cycle
        step(0, 0, 0, 0, 0, 1, 21'h100, 8'd1, 19'h5a5a, 4'hF, 0, "R10");
        step(1, va_of(21'h100), 8'd1, 2'd0, 0, 0, 0, 0, 0, 0, 0, "R10");
        // R2: same page, other process -> miss
        step(1, va_of(21'h100), 8'd2, 2'd0, 0, 0, 0, 0, 0, 0, 0, "R2");
        // R3: read-only supervisor page
        step(0, 0, 0, 0, 0, 1, 21'h200, 8'd1, 19'h0123, 4'b0001, 0, "R3");
        step(1, va_of(21'h200), 8'd1, 2'd1, 0, 0, 0, 0, 0, 0, 0, "R3");
        step(1, va_of(21'h200), 8'd1, 2'd0, 1, 0, 0, 0, 0, 0, 0, "R3");
        step(1, va_of(21'h200), 8'd1, 2'd3, 0, 0, 0, 0, 0, 0, 0, "R3");
        // R8: overwrite existing page with new frame
        step(0, 0, 0, 0, 0, 1, 21'h100, 8'd1, 19'h7777, 4'hF, 0, "R8");
        step(1, va_of(21'h100), 8'd1, 2'd2, 1, 0, 0, 0, 0, 0, 0, "R8");
        // R5: lookup in flush cycle sees old, refill dropped, then empty
        step(1, va_of(21'h100), 8'd1, 2'd0, 0, 1, 21'h300, 8'd1, 19'h1, 4'hF, 1, "R5");
        step(1, va_of(21'h300), 8'd1, 2'd0, 0, 0, 0, 0, 0, 0, 0, "R5");
        step(1, va_of(21'h100), 8'd1, 2'd0, 0, 0, 0, 0, 0, 0, 0, "R5");
        // R6/R7: fill all, touch all but page 7, then evict
        for (int k = 0; k < N; k++)
            step(0, 0, 0, 0, 0, 1, 21'(16'h400 + k), 8'd3, 19'(k + 1), 4'hF, 0, "R6");
        for (int k = 0; k < N - 1; k++)
            step(1, va_of(21'(16'h400 + k)), 8'd3, 2'd0, 0, 0, 0, 0, 0, 0, 0, "R7");
        step(0, 0, 0, 0, 0, 1, 21'h500, 8'd3, 19'h99, 4'hF, 0, "R7");
        step(1, va_of(21'(16'h400 + N - 1)), 8'd3, 2'd0, 0, 0, 0, 0, 0, 0, 0, "R7");
        step(1, va_of(21'h400), 8'd3, 2'd0, 0, 0, 0, 0, 0, 0, 0, "R7");
        // R4: idle lookup
        step(0, 32'hFFFF_FFFF, 8'd3, 2'd0, 0, 0, 0, 0, 0, 0, 0, "R4");

        // random mix against the model
        for (int c = 0; c < 4000; c++) begin
            logic [20:0] v, rv;
            logic [7:0]  p, rp;
            v  = 21'(16'h600 + ($urandom % 12));
            rv = 21'(16'h600 + ($urandom % 12));
            p  = 8'($urandom % 3);
            rp = 8'($urandom % 3);
            step($urandom % 4 != 0, va_of(v), p, 2'($urandom), 1'($urandom % 4 == 0),
                 $urandom % 3 == 0, rv, rp, 19'($urandom), 4'($urandom | 1),
                 $urandom % 40 == 0, "");
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule